// File: doc/BRIEF.md
# GP-Relative Load/Store Execution Unit

This unit executes a small family of custom instructions whose memory addresses are always formed from the global pointer register (x3) plus an immediate. No rs1 field is used. The family has signed and unsigned byte and halfword loads, a word load, byte, halfword and word stores, and an add-immediate-to-GP that writes the sum to a destination register without touching memory. The immediates are 18 or 19 bits wide and their bits are spread across the instruction word. The spreading pattern differs between the load shapes and the store shape, and between access widths.

The surrounding core presents one 32-bit instruction word with a valid strobe. In the same cycle it supplies the current x3 value and the value of the store-data register that the unit names on `rs2_idx_o`. Memory operations go out on a single-request port with registered outputs. The request is held until `mem_ready_i` is seen, and a load's register write follows in the cycle after that. The unit ignores new instructions while a request is outstanding. Encodings it does not recognise give a one-cycle illegal pulse and nothing else.

Top module: `gpx_exec_unit`

## Requirements
- R1: Under major opcode 0001011 (ins[6:0]), ins[13:12] selects the operation: 00 signed byte load, 10 unsigned byte load, 11 byte store, 01 add-immediate-to-GP.
- R2: Under major opcode 0101011, ins[14:12] selects the operation: 001 signed halfword load, 101 unsigned halfword load, 000 halfword store, 010 word load, 100 word store.
- R3: Byte loads and add-to-GP take an 18-bit immediate with imm[17]=ins[31], imm[16:15]=ins[16:15], imm[14:12]=ins[19:17], imm[11]=ins[20], imm[10:1]=ins[30:21] and imm[0]=ins[14]. Byte stores take imm[11]=ins[7], imm[10:5]=ins[30:25], imm[4:2]=ins[11:9], imm[1]=ins[8] and imm[0]=ins[14], with the upper bits as for loads. The store-data register index ins[24:20] appears on `rs2_idx_o`. Both immediates are sign-extended.
- R4: Halfword loads and stores use the byte-load and byte-store layouts with imm[0]=0. A word load uses a 19-bit immediate with imm[18]=ins[31], imm[17]=ins[21], imm[11]=ins[20], imm[10:2]=ins[30:22] and imm[1:0]=0. A word store uses the byte-store layout with imm[18]=ins[31] and imm[1:0]=0. Both are sign-extended from 19 bits.
- R5: Every effective address equals x3 plus the sign-extended immediate. Add-to-GP drives `rd_we_o` high for one cycle, one cycle after issue, with that sum on `rd_data_o` and ins[11:7] on `rd_idx_o`, and raises no memory request.
- R6: A load writes its datum to ins[11:7], taken from byte lane addr[1:0] for bytes, from the half selected by addr[1] for halfwords, or as the full word. Signed forms sign-extend bytes and halfwords to 32 bits and unsigned forms zero-extend them.
- R7: A store drives `mem_we_o`=1. Byte enables are 1<<addr[1:0] for a byte, 0011 or 1100 by addr[1] for a halfword, and 1111 for a word. The byte or halfword datum is replicated into every lane of `mem_wdata_o`.
- R8: A memory request appears one cycle after issue and is held with stable address, data and enables until the cycle in which `mem_ready_i` is high. It drops one cycle after that. A load's `rd_we_o` pulse comes in that same cycle and never while the request is outstanding.
- R9: An unrecognised opcode or function field raises `illegal_o` for exactly one cycle. It causes no register write and no memory request.
- R10: While a request is outstanding (`busy_o`=1), `ins_valid_i` is ignored. No write, request or illegal pulse results from it.
- R11: Synchronous reset clears `rd_we_o`, `mem_req_o`, `busy_o` and `illegal_o`, and abandons any outstanding request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid_i | input | 1 | Instruction word valid |
| ins_word_i | input | 32 | Instruction word |
| gp_val_i | input | XLEN | Current x3 value |
| rs2_idx_o | output | 5 | Store-data register index for the register file |
| rs2_val_i | input | XLEN | Value read from `rs2_idx_o` |
| rd_we_o | output | 1 | Destination register write strobe |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | XLEN | Destination register data |
| mem_req_o | output | 1 | Memory request outstanding |
| mem_we_o | output | 1 | Request is a store |
| mem_addr_o | output | XLEN | Byte address |
| mem_wdata_o | output | XLEN | Lane-replicated store data |
| mem_be_o | output | XLEN/8 | Byte enables |
| mem_rdata_i | input | XLEN | Load data, valid with `mem_ready_i` |
| mem_ready_i | input | 1 | Memory completes the request this cycle |
| busy_o | output | 1 | Request outstanding; instructions ignored |
| illegal_o | output | 1 | Unrecognised encoding pulse |

## Verification
The assertions assume that memory answers only a request it can see and that `mem_rdata_i` is valid in the cycle `mem_ready_i` is high. They also assume that halfword and word addresses are naturally aligned, because misaligned lane selection is left undefined. The stimulus raises ready only while `mem_req_o` is high and returns load data in that same cycle. It picks x3 and immediate pairs whose sums are aligned for their width. It draws immediates only from the range each form can encode, including both signed extremes.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  localparam logic [6:0] OPC_BYTE_CLASS = 7'b0001011;
  localparam logic [6:0] OPC_WIDE_CLASS = 7'b0101011;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      legal;
    logic      is_add;
    logic      is_store;
    logic      is_signed;
    acc_size_e size;
    logic [4:0]  rd;
    logic [4:0]  rs2;
    logic [31:0] imm;
  } dec_t;

endpackage

// File: rtl/gpx_decode.sv
module gpx_decode
  import gpx_pkg::*;
(
  input  logic [31:0] ins_i,
  output dec_t        dec_o
);

  logic [17:0] imm_ld;
  logic [17:0] imm_st;
  logic [18:0] imm_lw;
  logic [18:0] imm_sw;

  // scattered immediate layouts
  assign imm_ld = {ins_i[31], ins_i[16:15], ins_i[19:17], ins_i[20], ins_i[30:21], ins_i[14]};
  assign imm_st = {ins_i[31], ins_i[16:15], ins_i[19:17], ins_i[7], ins_i[30:25],
                   ins_i[11:9], ins_i[8], ins_i[14]};
  assign imm_lw = {ins_i[31], ins_i[21], ins_i[16:15], ins_i[19:17], ins_i[20],
                   ins_i[30:22], 2'b00};
  assign imm_sw = {ins_i[31], imm_st[17:2], 2'b00};

  always_comb begin
    dec_o           = '0;
    dec_o.rd        = ins_i[11:7];
    dec_o.rs2       = ins_i[24:20];
    dec_o.size      = SZ_B;
    if (ins_i[6:0] == OPC_BYTE_CLASS) begin
      dec_o.legal = 1'b1;
      dec_o.imm   = {{14{imm_ld[17]}}, imm_ld};
      unique case (ins_i[13:12])
        2'b00: dec_o.is_signed = 1'b1;
        2'b10: dec_o.is_signed = 1'b0;
        2'b01: dec_o.is_add    = 1'b1;
        default: begin
          dec_o.is_store = 1'b1;
          dec_o.imm      = {{14{imm_st[17]}}, imm_st};
        end
      endcase
    end else if (ins_i[6:0] == OPC_WIDE_CLASS) begin
      dec_o.legal = 1'b1;
      unique case (ins_i[14:12])
        3'b001, 3'b101: begin
          dec_o.size      = SZ_H;
          dec_o.is_signed = ~ins_i[14];
          dec_o.imm       = {{14{imm_ld[17]}}, imm_ld[17:1], 1'b0};
        end
        3'b000: begin
          dec_o.size     = SZ_H;
          dec_o.is_store = 1'b1;
          dec_o.imm      = {{14{imm_st[17]}}, imm_st[17:1], 1'b0};
        end
        3'b010: begin
          dec_o.size = SZ_W;
          dec_o.imm  = {{13{imm_lw[18]}}, imm_lw};
        end
        3'b100: begin
          dec_o.size     = SZ_W;
          dec_o.is_store = 1'b1;
          dec_o.imm      = {{13{imm_sw[18]}}, imm_sw};
        end
        default: dec_o.legal = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpx_store_lanes.sv
module gpx_store_lanes
  import gpx_pkg::*;
#(
  parameter int XLEN  = 32,
  localparam int LANES = XLEN / 8,
  localparam int LIW   = $clog2(LANES)
) (
  input  acc_size_e         size_i,
  input  logic [LIW-1:0]    lo_i,
  input  logic [XLEN-1:0]   src_i,
  output logic [XLEN-1:0]   wdata_o,
  output logic [LANES-1:0]  be_o
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wdata_o[8*i +: 8] = (size_i == SZ_B) ? src_i[7:0] :
                               (size_i == SZ_H) ? src_i[8*(i%2) +: 8] :
                                                  src_i[8*(i%4) +: 8];
    assign be_o[i] = (size_i == SZ_B) ? (lo_i == LIW'(i)) :
                     (size_i == SZ_H) ? ((lo_i >> 1) == LIW'(i/2)) :
                                        ((lo_i >> 2) == LIW'(i/4));
  end

endmodule

// File: rtl/gpx_load_extend.sv
module gpx_load_extend
  import gpx_pkg::*;
#(
  parameter int XLEN  = 32,
  localparam int LANES = XLEN / 8,
  localparam int LIW   = $clog2(LANES),
  localparam int SHW   = $clog2(XLEN) + 1
) (
  input  acc_size_e        size_i,
  input  logic             signed_i,
  input  logic [LIW-1:0]   lo_i,
  input  logic [XLEN-1:0]  rdata_i,
  output logic [XLEN-1:0]  value_o
);

  logic [LIW-1:0]  lo_m;
  logic [LIW+2:0]  lane_sh;
  logic [SHW-1:0]  top_sh;
  logic [XLEN-1:0] lane_val;
  logic [XLEN-1:0] left_val;

  always_comb begin
    unique case (size_i)
      SZ_B:    begin lo_m = lo_i;              top_sh = SHW'(XLEN - 8);  end
      SZ_H:    begin lo_m = lo_i & ~LIW'(1);   top_sh = SHW'(XLEN - 16); end
      default: begin lo_m = lo_i & ~LIW'(3);   top_sh = SHW'(XLEN - 32); end
    endcase
    lane_sh  = {lo_m, 3'b000};
    lane_val = rdata_i >> lane_sh;
    left_val = lane_val << top_sh;
    value_o  = signed_i ? XLEN'($signed(left_val) >>> top_sh) : (left_val >> top_sh);
  end

endmodule

// File: rtl/gpx_exec_unit.sv
module gpx_exec_unit
  import gpx_pkg::*;
#(
  parameter int XLEN  = 32,
  localparam int LANES = XLEN / 8,
  localparam int LIW   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid_i,
  input  logic [31:0]       ins_word_i,
  input  logic [XLEN-1:0]   gp_val_i,
  output logic [4:0]        rs2_idx_o,
  input  logic [XLEN-1:0]   rs2_val_i,
  output logic              rd_we_o,
  output logic [4:0]        rd_idx_o,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              illegal_o
);

  typedef enum logic { ST_IDLE, ST_WAIT } state_e;

  state_e          state_q;
  dec_t            dec;
  logic [XLEN-1:0] eff_addr;
  logic [XLEN-1:0] st_wdata;
  logic [LANES-1:0] st_be;
  logic [XLEN-1:0] ld_value;
  acc_size_e       size_q;
  logic            signed_q;

  gpx_decode u_decode (
    .ins_i (ins_word_i),
    .dec_o (dec)
  );

  assign eff_addr  = gp_val_i + XLEN'($signed(dec.imm));
  assign rs2_idx_o = dec.rs2;

  gpx_store_lanes #(.XLEN(XLEN)) u_lanes (
    .size_i  (dec.size),
    .lo_i    (eff_addr[LIW-1:0]),
    .src_i   (rs2_val_i),
    .wdata_o (st_wdata),
    .be_o    (st_be)
  );

  gpx_load_extend #(.XLEN(XLEN)) u_ldext (
    .size_i   (size_q),
    .signed_i (signed_q),
    .lo_i     (mem_addr_o[LIW-1:0]),
    .rdata_i  (mem_rdata_i),
    .value_o  (ld_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rd_we_o     <= 1'b0;
      rd_idx_o    <= '0;
      rd_data_o   <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_be_o    <= '0;
      size_q      <= SZ_B;
      signed_q    <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      rd_we_o   <= 1'b0;
      illegal_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ins_valid_i) begin
            if (!dec.legal) begin
              illegal_o <= 1'b1;
            end else if (dec.is_add) begin
              rd_we_o   <= 1'b1;
              rd_idx_o  <= dec.rd;
              rd_data_o <= eff_addr;
            end else begin
              mem_req_o   <= 1'b1;
              mem_we_o    <= dec.is_store;
              mem_addr_o  <= eff_addr;
              mem_wdata_o <= dec.is_store ? st_wdata : '0;
              mem_be_o    <= dec.is_store ? st_be : '0;
              size_q      <= dec.size;
              signed_q    <= dec.is_signed;
              rd_idx_o    <= dec.rd;
              state_q     <= ST_WAIT;
            end
          end
        end
        default: begin
          if (mem_ready_i) begin
            mem_req_o <= 1'b0;
            state_q   <= ST_IDLE;
            if (!mem_we_o) begin
              rd_we_o   <= 1'b1;
              rd_data_o <= ld_value;
            end
          end
        end
      endcase
    end
  end

  assign busy_o = (state_q == ST_WAIT);

  // Request held steady until memory accepts it
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_wdata_o) && $stable(mem_be_o));

  assert_req_release_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_ready_i |=> !mem_req_o);

  assert_wb_not_pending_R8: assert property (@(posedge clk) disable iff (rst)
    rd_we_o |-> !mem_req_o);

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !rd_we_o && !mem_req_o);

  assert_busy_no_decode_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !illegal_o);

  assert_store_be_width_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_we_o |-> ($countones(mem_be_o) == 1) ||
                             ($countones(mem_be_o) == 2) ||
                             ($countones(mem_be_o) == 4));

endmodule

// File: tb/gpx_exec_unit_tb_top.sv
`timescale 1ns/1ps
module gpx_exec_unit_tb_top;

  localparam int OP_LB = 0, OP_LBU = 1, OP_SB = 2, OP_ADD = 3, OP_LH = 4,
                 OP_LHU = 5, OP_SH = 6, OP_LW = 7, OP_SW = 8;
  localparam logic [4:0] RD_SEL = 5'd9;
  localparam logic [4:0] RS_SEL = 5'd14;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] imm;
    logic [31:0] gp;
    logic [31:0] dat;
    logic [31:0] expv;
    logic [3:0]  expbe;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    {4'd0, 32'h00000005, 32'h00001000, 32'h11228344, 32'hFFFFFF83, 4'h0},
    {4'd1, 32'h00000005, 32'h00001000, 32'h11228344, 32'h00000083, 4'h0},
    {4'd0, 32'hFFFFFFFD, 32'h00002002, 32'h7F000000, 32'h0000007F, 4'h0},
    {4'd3, 32'hFFFE0000, 32'h10000000, 32'h00000000, 32'h0FFE0000, 4'h0},
    {4'd3, 32'h0001FFFF, 32'h00000000, 32'h00000000, 32'h0001FFFF, 4'h0},
    {4'd4, 32'h00001A46, 32'h00003000, 32'h80011234, 32'hFFFF8001, 4'h0},
    {4'd5, 32'h00001A46, 32'h00003000, 32'h80011234, 32'h00008001, 4'h0},
    {4'd7, 32'hFFFFFFFC, 32'h00004000, 32'hDEADBEEF, 32'hDEADBEEF, 4'h0},
    {4'd7, 32'h0003FFFC, 32'h00000000, 32'h01020304, 32'h01020304, 4'h0},
    {4'd2, 32'h000002A7, 32'h00005000, 32'h000000C5, 32'hC5C5C5C5, 4'h8},
    {4'd2, 32'hFFFE0000, 32'h00020002, 32'h000000AB, 32'hABABABAB, 4'h4},
    {4'd6, 32'h000001F2, 32'h00006000, 32'hFFFF1357, 32'h13571357, 4'hC},
    {4'd8, 32'hFFFFFFF8, 32'h00007000, 32'hCAFEF00D, 32'hCAFEF00D, 4'hF},
    {4'd8, 32'h0001FFFC, 32'h00000100, 32'h12345678, 32'h12345678, 4'hF},
    {4'd4, 32'hFFFFFFFE, 32'h00000012, 32'hAAAA7FFF, 32'h00007FFF, 4'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid_i = 1'b0;
  logic [31:0] ins_word_i = '0;
  logic [31:0] gp_val_i = '0;
  logic [4:0]  rs2_idx_o;
  logic [31:0] rs2_val_i = '0;
  logic        rd_we_o;
  logic [4:0]  rd_idx_o;
  logic [31:0] rd_data_o;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;
  logic        busy_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpx_exec_unit #(.XLEN(32)) dut_i (
    .clk(clk), .rst(rst), .ins_valid_i(ins_valid_i), .ins_word_i(ins_word_i),
    .gp_val_i(gp_val_i), .rs2_idx_o(rs2_idx_o), .rs2_val_i(rs2_val_i),
    .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_rdata_i(mem_rdata_i),
    .mem_ready_i(mem_ready_i), .busy_o(busy_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit is_store(input int op);
    return op == OP_SB || op == OP_SH || op == OP_SW;
  endfunction

  // Build an instruction word from the requirement layouts (R1..R4)
  function automatic logic [31:0] enc(input int op, input logic [31:0] im);
    logic [31:0] w;
    w = '0;
    if (op == OP_LW) begin
      w[31] = im[18]; w[30:22] = im[10:2]; w[21] = im[17]; w[20] = im[11];
      w[19:17] = im[14:12]; w[16:15] = im[16:15]; w[11:7] = RD_SEL;
    end else if (is_store(op)) begin
      w[31] = im[17]; w[30:25] = im[10:5]; w[24:20] = RS_SEL; w[19:17] = im[14:12];
      w[16:15] = im[16:15]; w[14] = im[0]; w[11:9] = im[4:2]; w[8] = im[1]; w[7] = im[11];
    end else begin
      w[31] = im[17]; w[30:21] = im[10:1]; w[20] = im[11]; w[19:17] = im[14:12];
      w[16:15] = im[16:15]; w[14] = im[0]; w[11:7] = RD_SEL;
    end
    case (op)
      OP_LB:  begin w[13:12] = 2'b00; w[6:0] = 7'b0001011; end
      OP_LBU: begin w[13:12] = 2'b10; w[6:0] = 7'b0001011; end
      OP_SB:  begin w[13:12] = 2'b11; w[6:0] = 7'b0001011; end
      OP_ADD: begin w[13:12] = 2'b01; w[6:0] = 7'b0001011; end
      OP_LH:  begin w[14:12] = 3'b001; w[6:0] = 7'b0101011; end
      OP_LHU: begin w[14:12] = 3'b101; w[6:0] = 7'b0101011; end
      OP_SH:  begin w[14:12] = 3'b000; w[6:0] = 7'b0101011; end
      OP_LW:  begin w[14:12] = 3'b010; w[6:0] = 7'b0101011; end
      default: begin w[14:12] = 3'b100; w[6:0] = 7'b0101011; end
    endcase
    return w;
  endfunction

  task automatic run_vec(input vec_t v, input int lat);
    int op;
    bit held;
    op = int'(v.op);
    @(negedge clk);
    ins_valid_i = 1'b1;
    ins_word_i  = enc(op, v.imm);
    gp_val_i    = v.gp;
    rs2_val_i   = is_store(op) ? v.dat : 32'h5A5A5A5A;
    #1;
    if (is_store(op)) chk("R3 rs2 index", {27'd0, rs2_idx_o}, {27'd0, RS_SEL});
    @(negedge clk);
    ins_valid_i = 1'b0;
    ins_word_i  = '0;
    gp_val_i    = 32'h0BAD0000;
    rs2_val_i   = 32'h0;
    if (op == OP_ADD) begin
      chk("R5 add write", {rd_we_o, mem_req_o, 25'd0, rd_idx_o}, {2'b10, 25'd0, RD_SEL});
      chk("R5 add sum", rd_data_o, v.expv);
      @(negedge clk);
      chk("R5 add one pulse", {31'd0, rd_we_o}, 32'd0);
      return;
    end
    chk("R5 request address", mem_addr_o, v.gp + v.imm);
    chk("R8 request raised", {30'd0, mem_req_o, busy_o}, 32'd3);
    if (is_store(op)) begin
      chk("R7 store enables", {27'd0, mem_we_o, mem_be_o}, {27'd0, 1'b1, v.expbe});
      chk("R7 store data", mem_wdata_o, v.expv);
    end else begin
      chk("R6 load direction", {31'd0, mem_we_o}, 32'd0);
    end
    held = 1'b1;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      if (!mem_req_o || rd_we_o || mem_addr_o !== v.gp + v.imm) held = 1'b0;
    end
    if (lat > 0) chk("R8 hold until ready", {31'd0, held}, 32'd1);
    mem_ready_i = 1'b1;
    mem_rdata_i = is_store(op) ? 32'hFFFFFFFF : v.dat;
    @(negedge clk);
    mem_ready_i = 1'b0;
    mem_rdata_i = 32'h0;
    chk("R8 request dropped", {31'd0, mem_req_o}, 32'd0);
    if (is_store(op)) begin
      chk("R7 store no write", {31'd0, rd_we_o}, 32'd0);
    end else begin
      chk("R6 load write", {26'd0, rd_we_o, rd_idx_o}, {26'd0, 1'b1, RD_SEL});
      chk("R6 load value", rd_data_o, v.expv);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {28'd0, rd_we_o, mem_req_o, busy_o, illegal_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 4);

    // R9 unknown major opcode
    @(negedge clk);
    ins_valid_i = 1'b1; ins_word_i = 32'h00000033;
    @(negedge clk);
    ins_valid_i = 1'b0; ins_word_i = '0;
    chk("R9 illegal opcode", {29'd0, illegal_o, rd_we_o, mem_req_o}, 32'd4);
    @(negedge clk);
    chk("R9 illegal single cycle", {31'd0, illegal_o}, 32'd0);

    // R2 R9 unused function code 011 under the wide opcode
    ins_valid_i = 1'b1; ins_word_i = 32'h0000302B;
    @(negedge clk);
    ins_valid_i = 1'b0; ins_word_i = '0;
    chk("R2 R9 illegal funct", {29'd0, illegal_o, rd_we_o, mem_req_o}, 32'd4);
    @(negedge clk);

    // R10 instructions ignored while busy
    ins_valid_i = 1'b1; ins_word_i = enc(OP_LW, 32'h00000010); gp_val_i = 32'h100;
    @(negedge clk);
    ins_word_i = enc(OP_ADD, 32'h00000001);
    @(negedge clk);
    ins_word_i = 32'h00000033;
    @(negedge clk);
    ins_valid_i = 1'b0; ins_word_i = '0;
    chk("R10 busy no side effect", {29'd0, rd_we_o, illegal_o, mem_req_o}, 32'd1);
    chk("R10 address kept", mem_addr_o, 32'h110);
    mem_ready_i = 1'b1; mem_rdata_i = 32'h600DF00D;
    @(negedge clk);
    mem_ready_i = 1'b0;
    chk("R10 only load writes", rd_data_o, 32'h600DF00D);
    @(negedge clk);
    chk("R10 no late write", {30'd0, rd_we_o, illegal_o}, 32'd0);

    // R11 reset abandons an outstanding request
    ins_valid_i = 1'b1; ins_word_i = enc(OP_SW, 32'h00000020); gp_val_i = 32'h40;
    rs2_val_i = 32'h1;
    @(negedge clk);
    ins_valid_i = 1'b0;
    chk("R11 request before reset", {31'd0, mem_req_o}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset clears request", {30'd0, mem_req_o, busy_o}, 32'd0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule